// File: doc/BRIEF.md
# Eight-Point Fixed-Point IDCT Row Unit

This block performs a one-dimensional eight-point inverse discrete cosine transform on one row of eight signed 16-bit coefficients. The cosine weights are integers scaled by 2^14. The transform is built as an even/odd butterfly. A row arrives in parallel on a valid/ready handshake. One registered cycle later, the eight signed 16-bit results leave on a valid/ready output.

Before the row is stored, two shortcuts are decided from the row itself. When every coefficient except the first is zero, the block skips the weighted sums and writes the first coefficient, multiplied by eight, into all eight lanes. When only the upper four coefficients are zero, the result comes from a reduced sum that omits them, and it matches the full computation bit for bit. A 2-D transform uses the block as its row pass. Transposition, column passes and pixel clamping live elsewhere.

Top module: `idct8_row_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after reset releases, `out_valid` is 0.
- R2: `in_ready` equals `!out_valid || out_ready`, and a row is accepted on a rising clock edge where `in_valid && in_ready`. While `in_ready` is 0, `in_valid` and `in_row` have no effect.
- R3: The result of an accepted row is on `out_row` with `out_valid` = 1 after exactly one clock edge. The latency is the same for the DC, reduced and full paths, and rows sent back to back stream at one per cycle.
- R4: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_row` hold their values.
- R5: The weights are W1=22725, W2=21407, W3=19266, W4=16383, W5=12873, W6=8867 and W7=4520.
  - The even sums are E0=W4x0+W2x2+W4x4+W6x6, E1=W4x0+W6x2−W4x4−W2x6, E2=W4x0−W6x2−W4x4+W2x6 and E3=W4x0−W2x2+W4x4−W6x6.
  - Each even sum has 1024 added.
  - The odd sums are O0=W1x1+W3x3+W5x5+W7x7, O1=W3x1−W7x3−W1x5−W5x7, O2=W5x1−W1x3+W7x5+W3x7 and O3=W7x1−W5x3+W3x5−W1x7.
- R6: y_k = (E_k+O_k)>>>11 and y_(7−k) = (E_k−O_k)>>>11 for k = 0..3. The shift is arithmetic, and each y is truncated to its low 16 bits in two's complement.
- R7: When x1..x7 are all zero, every y equals the low 16 bits of x0·8. This includes x0 = 4096, which gives 0x8000, and x0 = −32768, which gives 0.
- R8: When x4..x7 are all zero and some x1..x3 is nonzero, the output equals the R5/R6 result exactly.
- R9: Coefficient x_i sits at `in_row[16i+15:16i]`, and y_i sits at `out_row[16i+15:16i]`.
- R10: Internal sums do not overflow. Rows made of full-scale values give the exact R5/R6 result modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Unit can take a row this cycle |
| in_row | input | 128 | Eight packed signed coefficients, x0 in the low lane |
| out_valid | output | 1 | Result row held on out_row |
| out_ready | input | 1 | Consumer takes the result |
| out_row | output | 128 | Eight packed signed results, y0 in the low lane |

## Verification
The bench aims at the boundary between paths.

- Rows where only x0 is set must take the shortcut. A unit that sent them down the weighted path would return about 8·x0 minus a small error instead of exactly x0·8.
- A DC value of 4096 checks the wrap to 0x8000.
- Rows with a single nonzero coefficient in an odd lane or an upper lane expose a swapped butterfly sign or a lane-packing error.
- Rows with the upper half zero catch a reduced path that drops a lower term or forgets the rounding bias.
- Full-scale rows reveal a sum that is too narrow, because the wrapped value differs from the exact result.
- A stall test covers a unit that overwrites its result, or accepts a new row, while the consumer is not ready.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int COEF_W    = 16;
    localparam int LANES     = 8;
    localparam int HALF      = LANES / 2;
    localparam int ROW_W     = COEF_W * LANES;
    localparam int ACC_W     = 2 * COEF_W + 2;
    localparam int ROW_SHIFT = 11;
    localparam int DC_SHIFT  = 3;

    localparam int W1 = 22725;
    localparam int W2 = 21407;
    localparam int W3 = 19266;
    localparam int W4 = 16383;
    localparam int W5 = 12873;
    localparam int W6 = 8867;
    localparam int W7 = 4520;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam acc_t ROUND_BIAS = acc_t'(1 << (ROW_SHIFT - 1));

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } out_state_t;

    function automatic acc_t mul_w(input coef_t x, input int w);
        return acc_t'(x) * acc_t'(w);
    endfunction

endpackage

// File: rtl/idct8_lower.sv
// Contribution of x0..x3 to the even and odd sums, rounding bias included.
module idct8_lower
    import idct8_pkg::*;
(
    input  coef_t x0_i,
    input  coef_t x1_i,
    input  coef_t x2_i,
    input  coef_t x3_i,
    output acc_t  even_o [HALF],
    output acc_t  odd_o  [HALF]
);

    acc_t dc_term;

    always_comb begin
        dc_term  = mul_w(x0_i, W4) + ROUND_BIAS;
        even_o[0] = dc_term + mul_w(x2_i, W2);
        even_o[1] = dc_term + mul_w(x2_i, W6);
        even_o[2] = dc_term - mul_w(x2_i, W6);
        even_o[3] = dc_term - mul_w(x2_i, W2);
        odd_o[0]  = mul_w(x1_i, W1) + mul_w(x3_i, W3);
        odd_o[1]  = mul_w(x1_i, W3) - mul_w(x3_i, W7);
        odd_o[2]  = mul_w(x1_i, W5) - mul_w(x3_i, W1);
        odd_o[3]  = mul_w(x1_i, W7) - mul_w(x3_i, W5);
    end

endmodule

// File: rtl/idct8_upper.sv
// Contribution of x4..x7 to the even and odd sums.
module idct8_upper
    import idct8_pkg::*;
(
    input  coef_t x4_i,
    input  coef_t x5_i,
    input  coef_t x6_i,
    input  coef_t x7_i,
    output acc_t  even_o [HALF],
    output acc_t  odd_o  [HALF]
);

    acc_t p4;

    always_comb begin
        p4        = mul_w(x4_i, W4);
        even_o[0] =  p4 + mul_w(x6_i, W6);
        even_o[1] = -p4 - mul_w(x6_i, W2);
        even_o[2] = -p4 + mul_w(x6_i, W2);
        even_o[3] =  p4 - mul_w(x6_i, W6);
        odd_o[0]  =  mul_w(x5_i, W5) + mul_w(x7_i, W7);
        odd_o[1]  = -mul_w(x5_i, W1) - mul_w(x7_i, W5);
        odd_o[2]  =  mul_w(x5_i, W7) + mul_w(x7_i, W3);
        odd_o[3]  =  mul_w(x5_i, W3) - mul_w(x7_i, W1);
    end

endmodule

// File: rtl/idct8_merge.sv
// Output butterfly: sum/difference, arithmetic shift, truncation to lane width.
module idct8_merge
    import idct8_pkg::*;
#(
    parameter int SHIFT = ROW_SHIFT
) (
    input  acc_t  even_i [HALF],
    input  acc_t  odd_i  [HALF],
    output coef_t y_o    [LANES]
);

    for (genvar k = 0; k < HALF; k++) begin : g_fly
        assign y_o[k]           = coef_t'((even_i[k] + odd_i[k]) >>> SHIFT);
        assign y_o[LANES-1-k]   = coef_t'((even_i[k] - odd_i[k]) >>> SHIFT);
    end

endmodule

// File: rtl/idct8_row_unit.sv
module idct8_row_unit
    import idct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_row,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row
);

    coef_t      x [LANES];
    acc_t       even_lo [HALF];
    acc_t       odd_lo  [HALF];
    acc_t       even_up [HALF];
    acc_t       odd_up  [HALF];
    acc_t       even_all[HALF];
    acc_t       odd_all [HALF];
    coef_t      y_full  [LANES];
    coef_t      y_half  [LANES];
    logic [ROW_W-1:0]  full_row;
    logic [ROW_W-1:0]  half_row;
    logic [ROW_W-1:0]  dc_row;
    logic [COEF_W-1:0] dc_lane;
    logic       dc_only;
    logic       upper_zero;
    out_state_t state_d;
    out_state_t state_q;

    for (genvar i = 0; i < LANES; i++) begin : g_unpack
        assign x[i] = in_row[i*COEF_W +: COEF_W];
    end

    // Path selection from the row contents
    always_comb begin
        dc_only    = (in_row[ROW_W-1:COEF_W] == '0);
        upper_zero = (in_row[ROW_W-1:ROW_W/2] == '0);
        dc_lane    = in_row[COEF_W-1:0] << DC_SHIFT;
    end

    idct8_lower i_lower (
        .x0_i   (x[0]),
        .x1_i   (x[1]),
        .x2_i   (x[2]),
        .x3_i   (x[3]),
        .even_o (even_lo),
        .odd_o  (odd_lo)
    );

    idct8_upper i_upper (
        .x4_i   (x[4]),
        .x5_i   (x[5]),
        .x6_i   (x[6]),
        .x7_i   (x[7]),
        .even_o (even_up),
        .odd_o  (odd_up)
    );

    for (genvar k = 0; k < HALF; k++) begin : g_join
        assign even_all[k] = even_lo[k] + even_up[k];
        assign odd_all[k]  = odd_lo[k]  + odd_up[k];
    end

    idct8_merge #(.SHIFT(ROW_SHIFT)) i_merge_full (
        .even_i (even_all),
        .odd_i  (odd_all),
        .y_o    (y_full)
    );

    idct8_merge #(.SHIFT(ROW_SHIFT)) i_merge_half (
        .even_i (even_lo),
        .odd_i  (odd_lo),
        .y_o    (y_half)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign full_row[i*COEF_W +: COEF_W] = y_full[i];
        assign half_row[i*COEF_W +: COEF_W] = y_half[i];
        assign dc_row[i*COEF_W +: COEF_W]   = dc_lane;
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        in_ready = !state_q.valid || out_ready;
        if (state_q.valid && out_ready) begin
            state_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            state_d.valid = 1'b1;
            if (dc_only) begin
                state_d.row = dc_row;
            end else if (upper_zero) begin
                state_d.row = half_row;
            end else begin
                state_d.row = full_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_row   = state_q.row;

endmodule

module idct8_row_unit_chk
    import idct8_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ROW_W-1:0] in_row,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row
);

    logic [COEF_W-1:0] exp_dc_lane;
    logic [ROW_W-1:0]  exp_dc_row;
    logic              take_dc;

    always_comb begin
        exp_dc_lane = in_row[COEF_W-1:0] << DC_SHIFT;
        exp_dc_row  = {LANES{exp_dc_lane}};
        take_dc     = in_valid && in_ready && (in_row[ROW_W-1:COEF_W] == '0);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

    // R3
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R3
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_row));

    // R7
    dc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_dc |=> out_row == $past(exp_dc_row));

endmodule

bind idct8_row_unit idct8_row_unit_chk i_chk (.*);

// File: tb/test_idct8_row_unit.sv
module test_idct8_row_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_row;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_row;

    int errors = 0;
    int checks = 0;
    int seed   = 32'h1234_5678;

    always #10 clk = ~clk;

    idct8_row_unit i_idct8_row_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_row    (in_row),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_row   (out_row)
    );

    // Independent reference built from R5..R7
    function automatic logic [127:0] ref_row(input logic [127:0] r);
        longint x[8];
        longint e[4];
        longint o[4];
        longint t;
        logic [127:0] res;
        for (int i = 0; i < 8; i++) x[i] = longint'($signed(r[16*i +: 16]));
        if (x[1] == 0 && x[2] == 0 && x[3] == 0 && x[4] == 0 &&
            x[5] == 0 && x[6] == 0 && x[7] == 0) begin
            t = x[0] * 8;
            for (int i = 0; i < 8; i++) res[16*i +: 16] = t[15:0];
            return res;
        end
        e[0] = 16383*x[0] + 21407*x[2] + 16383*x[4] +  8867*x[6] + 1024;
        e[1] = 16383*x[0] +  8867*x[2] - 16383*x[4] - 21407*x[6] + 1024;
        e[2] = 16383*x[0] -  8867*x[2] - 16383*x[4] + 21407*x[6] + 1024;
        e[3] = 16383*x[0] - 21407*x[2] + 16383*x[4] -  8867*x[6] + 1024;
        o[0] = 22725*x[1] + 19266*x[3] + 12873*x[5] +  4520*x[7];
        o[1] = 19266*x[1] -  4520*x[3] - 22725*x[5] - 12873*x[7];
        o[2] = 12873*x[1] - 22725*x[3] +  4520*x[5] + 19266*x[7];
        o[3] =  4520*x[1] - 12873*x[3] + 19266*x[5] - 22725*x[7];
        for (int k = 0; k < 4; k++) begin
            t = (e[k] + o[k]) >>> 11;
            res[16*k +: 16] = t[15:0];
            t = (e[k] - o[k]) >>> 11;
            res[16*(7-k) +: 16] = t[15:0];
        end
        return res;
    endfunction

    function automatic logic [127:0] mk_row(input int v0, input int v1, input int v2,
                                            input int v3, input int v4, input int v5,
                                            input int v6, input int v7);
        return {v7[15:0], v6[15:0], v5[15:0], v4[15:0],
                v3[15:0], v2[15:0], v1[15:0], v0[15:0]};
    endfunction

    function automatic logic [127:0] rnd_row(input int lanes);
        logic [127:0] r = '0;
        for (int i = 0; i < lanes; i++) begin
            seed = seed * 1103515245 + 12345;
            r[16*i +: 16] = seed[30:15];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one row with out_ready high and check the result one edge later
    task automatic send_row(input string req, input logic [127:0] r);
        @(negedge clk);
        in_valid  = 1'b1;
        in_row    = r;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid (R3)"}, {127'd0, out_valid}, 128'd1);
        chk(req, out_row, ref_row(r));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_row = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {127'd0, out_valid}, 128'd0);
        chk("R2 in_ready when empty", {127'd0, in_ready}, 128'd1);
    endtask

    task automatic t_dc;
        logic [127:0] r;
        send_row("R7 dc 5", mk_row(5, 0, 0, 0, 0, 0, 0, 0));
        chk("R7 dc 5 lane value", out_row, {8{16'd40}});
        send_row("R7 dc -7", mk_row(-7, 0, 0, 0, 0, 0, 0, 0));
        r = mk_row(4096, 0, 0, 0, 0, 0, 0, 0);
        send_row("R7 dc 4096", r);
        chk("R7 dc 4096 wraps", out_row, {8{16'h8000}});
        send_row("R7 dc -32768", mk_row(-32768, 0, 0, 0, 0, 0, 0, 0));
        chk("R7 dc -32768 wraps", out_row, '0);
        send_row("R7 dc zero row", '0);
    endtask

    task automatic t_lanes;
        for (int i = 0; i < 8; i++) begin
            logic [127:0] r = '0;
            r[16*i +: 16] = 16'd1000;
            send_row($sformatf("R9 single lane %0d", i), r);
        end
    endtask

    task automatic t_upper_zero;
        send_row("R8 x2 only", mk_row(0, 0, 300, 0, 0, 0, 0, 0));
        send_row("R8 x1 x3", mk_row(100, -250, 0, 777, 0, 0, 0, 0));
        for (int n = 0; n < 10; n++) send_row("R8 random lower half", rnd_row(4));
    endtask

    task automatic t_full;
        for (int n = 0; n < 20; n++) send_row("R5 R6 random full row", rnd_row(8));
        send_row("R6 negative mix", mk_row(-100, 55, -3000, 12, -1, 900, -32, 4));
    endtask

    task automatic t_extreme;
        send_row("R10 all max", {8{16'h7fff}});
        send_row("R10 all min", {8{16'h8000}});
        send_row("R10 alternating", mk_row(32767, -32768, 32767, -32768,
                                           32767, -32768, 32767, -32768));
        send_row("R10 sign pattern", mk_row(32767, 32767, 32767, 32767,
                                            -32768, -32768, -32768, 32767));
    endtask

    task automatic t_stall;
        logic [127:0] ra = mk_row(10, 20, 30, 40, 50, 60, 70, 80);
        logic [127:0] rb = mk_row(-9, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b1; in_row = ra; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_row = rb;
        chk("R2 in_ready low when full", {127'd0, in_ready}, 128'd0);
        repeat (3) @(negedge clk);
        chk("R4 held valid", {127'd0, out_valid}, 128'd1);
        chk("R4 held row, new row ignored (R2)", out_row, ref_row(ra));
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 row accepted on drain", out_row, ref_row(rb));
        @(posedge clk);
        @(negedge clk);
        chk("R3 empties after consume", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_stream;
        logic [127:0] rows [4];
        rows[0] = rnd_row(8);
        rows[1] = mk_row(77, 0, 0, 0, 0, 0, 0, 0);
        rows[2] = rnd_row(4);
        rows[3] = rnd_row(8);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_row    = rows[0];
        for (int n = 1; n <= 4; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3 back-to-back latency", out_row, ref_row(rows[n-1]));
            if (n < 4) in_row = rows[n];
            else in_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_dc();
        t_lanes();
        t_upper_zero();
        t_full();
        t_extreme();
        t_stall();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule